// File: doc/BRIEF.md
# PWM Colour Intensity Generator

This block drives three one-bit colour lines for an analog display. Each line carries a pulse train that an external low-pass filter turns into a voltage. The block takes a per-pixel colour beat and sets each line's duty cycle within a single pixel period, in steps of one eighth.

The block runs on a fast clock at four times the pixel rate. A two-bit phase counter counts the four fast cycles of a pixel. The level of the fast clock itself splits each fast cycle into two halves, which gives eight sub-slots per pixel. Each channel's 3-bit code sets how many sub-slots are high, and the high sub-slots sit at the start of the pixel. A full-on flag holds the line high for the whole pixel.

Beats arrive over a valid/ready stream. The block is ready for one fast cycle per pixel, the last one, so it accepts at most one beat per pixel. There is no buffering. If no beat is offered in that cycle, the next pixel is dark, so the source must keep pace with the pixel rate.

Top module: `pwm_color_gen`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_fast`, the phase counter returns to 0, `pwm_out` is all zero on both clock levels, and `in_ready` is low.
- R2: Once reset is released, `in_ready` is high in exactly one fast cycle in four. That cycle is the fourth fast cycle of every pixel, counting the cycle that follows the last reset edge as the first cycle of pixel 0.
- R3: If `in_valid` is low while `in_ready` is high, every channel stays low for the whole of the following pixel.
- R4: A channel with full flag 0 and code k (0 to 7) is high in exactly sub-slots 0 to k-1 of the pixel and low in the rest. Sub-slot s = 2*p + h, where p is the number of fast rising edges since the pixel began (0 to 3), h is 0 while `clk_fast` is high and 1 while it is low.
- R5: Code 0 with full flag 0 keeps the channel low in all eight sub-slots.
- R6: Full flag 1 keeps the channel high in all eight sub-slots, whatever its code.
- R7: A beat accepted with `in_blank` high keeps every channel low for the whole of the following pixel.
- R8: A beat takes effect only from the pixel that follows its acceptance. `in_data`, `in_blank` and `in_valid` have no effect in any fast cycle where `in_ready` is low.
- R9: Channel c takes its field from `in_data[4c+3:4c]`, with bit 3 as the full flag and bits 2:0 as the code. Channel 0 is red, 1 is green and 2 is blue, and channel c drives `pwm_out[c]`. The channels do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock at four times the pixel rate; both of its levels mark sub-slots |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A colour beat is offered |
| in_ready | output | 1 | High in the last fast cycle of a pixel; a beat is taken when valid and ready are both high |
| in_data | input | 12 | Three 4-bit channel fields, each a full flag and a 3-bit code |
| in_blank | input | 1 | Beat belongs to the blanking interval; outputs are dark for its pixel |
| pwm_out | output | 3 | Pulse outputs: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The assertions assume that `clk_fast` toggles with a roughly even duty cycle. They also assume that reset is held for at least one rising edge, and that the stream inputs settle well away from the rising edge. The stimulus changes every input at a falling edge and holds reset for several cycles. To exercise R8, it also drives a full-intensity beat with `in_valid` high in the cycles where `in_ready` is low. Outputs are sampled a quarter period after each clock transition, so each sub-slot is read while it is stable.

// File: rtl/pwm_color_pkg.sv
`timescale 1ns/1ps
package pwm_color_pkg;
  // bits in a channel field beyond the intensity code (the full-on flag)
  localparam int unsigned FLAG_BITS = 1;

  // true when the sub-slot falls inside the packed high run of a channel
  function automatic logic slot_lit(input logic full, input int unsigned code,
                                    input int unsigned slot);
    return full | (slot < code);
  endfunction
endpackage

// File: rtl/pwm_phase_track.sv
`timescale 1ns/1ps
module pwm_phase_track #(
  parameter int unsigned PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] phase_nxt,
  output logic               last
);
  localparam logic [PHASE_W-1:0] FINAL_PHASE = '1;
  localparam logic [PHASE_W-1:0] STEP = {{(PHASE_W-1){1'b0}}, 1'b1};

  assign phase_nxt = phase_q + STEP;
  assign last      = (phase_q == FINAL_PHASE);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_nxt;
  end
endmodule

// File: rtl/pwm_beat_capture.sv
`timescale 1ns/1ps
module pwm_beat_capture #(
  parameter int unsigned BEAT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_blank,
  output logic [BEAT_W-1:0] lvl_nxt,
  output logic              blank_q,
  output logic              blank_nxt
);
  logic [BEAT_W-1:0] lvl_q;
  logic              take;

  assign in_ready = last & ~rst;
  assign take     = in_valid & in_ready;

  always_comb begin
    if (last) begin
      lvl_nxt   = take ? in_data : '0;
      blank_nxt = take ? in_blank : 1'b1;
    end else begin
      lvl_nxt   = lvl_q;
      blank_nxt = blank_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      blank_q <= 1'b1;
    end else begin
      lvl_q   <= lvl_nxt;
      blank_q <= blank_nxt;
    end
  end

  // R8: the held beat only moves at a pixel boundary
  p_hold_mid_r8: assert property (@(posedge clk) disable iff (rst)
    !last |=> ($stable(lvl_q) && $stable(blank_q)));

  // R3: a boundary without a beat darkens the next pixel
  p_underflow_dark_r3: assert property (@(posedge clk) disable iff (rst)
    (last && !in_valid) |=> blank_q);
endmodule

// File: rtl/pwm_duty_decode.sv
`timescale 1ns/1ps
module pwm_duty_decode
  import pwm_color_pkg::*;
#(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code,
  input  logic               full,
  input  logic               blank,
  input  logic [PHASE_W-1:0] phase,
  output logic               hi_even_q,
  output logic               hi_odd_q
);
  logic even_on, odd_on;

  always_comb begin
    even_on = ~blank & slot_lit(full, int'(code), int'({phase, 1'b0}));
    odd_on  = ~blank & slot_lit(full, int'(code), int'({phase, 1'b1}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_even_q <= 1'b0;
      hi_odd_q  <= 1'b0;
    end else begin
      hi_even_q <= even_on;
      hi_odd_q  <= odd_on;
    end
  end

  // R4: high sub-slots are packed, so a lit odd half implies a lit even half
  p_packed_run_r4: assert property (@(posedge clk) disable iff (rst)
    hi_odd_q |-> hi_even_q);

  // R5: code zero without the flag stays dark
  p_code_zero_dark_r5: assert property (@(posedge clk) disable iff (rst)
    (!blank && !full && code == '0) |=> (!hi_even_q && !hi_odd_q));

  // R6: the full-on flag lights both halves
  p_full_on_r6: assert property (@(posedge clk) disable iff (rst)
    (!blank && full) |=> (hi_even_q && hi_odd_q));
endmodule

// File: rtl/pwm_color_gen.sv
`timescale 1ns/1ps
module pwm_color_gen
  import pwm_color_pkg::*;
#(
  parameter int unsigned CHANNELS = 3,
  parameter int unsigned CODE_W   = 3
) (
  input  logic                                     clk_fast,
  input  logic                                     rst,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [CHANNELS*(CODE_W+FLAG_BITS)-1:0]   in_data,
  input  logic                                     in_blank,
  output logic [CHANNELS-1:0]                      pwm_out
);
  localparam int unsigned FIELD_W = CODE_W + FLAG_BITS;
  localparam int unsigned BEAT_W  = CHANNELS * FIELD_W;
  localparam int unsigned PHASE_W = CODE_W - 1;

  logic [PHASE_W-1:0]  phase_q, phase_nxt;
  logic                last;
  logic [BEAT_W-1:0]   lvl_nxt;
  logic                blank_q, blank_nxt;
  logic [CHANNELS-1:0] hi_even, hi_odd;

  pwm_phase_track #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk_fast), .rst(rst), .phase_q(phase_q),
    .phase_nxt(phase_nxt), .last(last)
  );

  pwm_beat_capture #(.BEAT_W(BEAT_W)) u_capture (
    .clk(clk_fast), .rst(rst), .last(last), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_blank(in_blank),
    .lvl_nxt(lvl_nxt), .blank_q(blank_q), .blank_nxt(blank_nxt)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    pwm_duty_decode #(.CODE_W(CODE_W), .PHASE_W(PHASE_W)) u_decode (
      .clk(clk_fast), .rst(rst),
      .code(lvl_nxt[c*FIELD_W +: CODE_W]),
      .full(lvl_nxt[c*FIELD_W + CODE_W]),
      .blank(blank_nxt), .phase(phase_nxt),
      .hi_even_q(hi_even[c]), .hi_odd_q(hi_odd[c])
    );
    // high clock level is the even half of a fast cycle, low level the odd half
    assign pwm_out[c] = clk_fast ? hi_even[c] : hi_odd[c];
  end

  // R2: an accepting cycle is always followed by the start of a pixel
  p_ready_at_boundary_r2: assert property (@(posedge clk_fast) disable iff (rst)
    in_ready |=> (phase_q == '0));

  // R7: a blanked pixel holds every channel dark
  p_blank_dark_r7: assert property (@(posedge clk_fast) disable iff (rst)
    blank_q |-> (hi_even == '0 && hi_odd == '0));
endmodule

// File: tb/pwm_color_gen_test.sv
`timescale 1ns/1ps
module pwm_color_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_blank = 1'b0;
  logic [11:0] in_data = '0;
  wire         in_ready;
  wire  [2:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [23:0] expq[$];

  pwm_color_gen uut (
    .clk_fast(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_blank(in_blank), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  // fast cycles since reset release; phase within a pixel is cyc % 4
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R4/R5/R6 pattern: bit s is sub-slot s
  function automatic logic [7:0] pattern(input logic [3:0] f, input logic blank, input logic valid);
    if (!valid || blank) return 8'h00;    // R3, R7
    if (f[3]) return 8'hFF;               // R6
    return (8'h01 << f[2:0]) - 8'h01;     // R4, R5
  endfunction

  // driver: one call per pixel, beat offered in the ready cycle
  task automatic drive(input logic v, input logic [11:0] d, input logic b);
    do @(negedge clk); while (cyc % 4 != 3);
    in_valid = v; in_data = d; in_blank = b;
    expq.push_back({pattern(d[11:8], b, v), pattern(d[7:4], b, v), pattern(d[3:0], b, v)});
    @(negedge clk);
    // R8: loud beat offered while not ready must be ignored
    in_valid = 1'b1; in_data = 12'hFFF; in_blank = 1'b0;
  endtask

  // monitor: reads each sub-slot mid-half and compares whole pixels
  initial begin
    logic [7:0] ar, ag, ab;
    logic [23:0] e;
    int s;
    ar = '0; ag = '0; ab = '0;
    forever begin
      @(posedge clk);
      if (rst) continue;
      #2.5;
      s = 2 * (cyc % 4);
      ar[s] = pwm_out[0]; ag[s] = pwm_out[1]; ab[s] = pwm_out[2];
      #5;
      ar[s+1] = pwm_out[0]; ag[s+1] = pwm_out[1]; ab[s+1] = pwm_out[2];
      // R2: ready only in the last fast cycle of a pixel
      check(in_ready == (cyc % 4 == 3), "R2", int'(in_ready), int'(cyc % 4 == 3));
      if (cyc % 4 == 3 && cyc >= 7 && expq.size() > 0) begin
        e = expq.pop_front();
        // R9: each channel compared against its own field
        check(ar == e[7:0],   "R4 red",   int'(ar), int'(e[7:0]));
        check(ag == e[15:8],  "R4 green", int'(ag), int'(e[15:8]));
        check(ab == e[23:16], "R4 blue",  int'(ab), int'(e[23:16]));
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2.5;
    check(pwm_out == 3'b000, "R1 high half", int'(pwm_out), 0);
    @(negedge clk); #2.5;
    check(pwm_out == 3'b000, "R1 low half", int'(pwm_out), 0);
    check(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);
    @(negedge clk);
    rst = 1'b0;

    drive(1'b1, 12'h000, 1'b0);            // R5 all codes zero
    drive(1'b1, 12'h731, 1'b0);            // R4 R9 distinct codes per channel
    drive(1'b1, 12'h8A5, 1'b0);            // R6 flag with code 0 and code 2
    drive(1'b1, 12'hFFF, 1'b1);            // R7 blanked beat
    drive(1'b0, 12'h777, 1'b0);            // R3 no beat at the boundary
    drive(1'b1, 12'h642, 1'b0);            // R8 new level only from next pixel
    for (int k = 0; k < 16; k++)
      drive(1'b1, {4'(k), 4'(15 - k), 4'(k ^ 5)}, 1'b0);
    drive(1'b1, 12'h117, 1'b0);
    drive(1'b0, 12'h000, 1'b0);
    repeat (12) @(negedge clk);
    check(expq.size() == 0, "R4 drained", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule